// File: doc/BRIEF.md
# Code Jump Upset Monitor

This block watches the digital output of a fast converter while the converter is exposed to particle beams. The test setup feeds the converter a slowly drifting beat-frequency signal. When nothing is wrong, neighbouring output codes differ by well under one step. Any jump larger than a software-chosen margin is therefore treated as an upset. A margin of 6 LSB is the usual setting, chosen to cover background noise.

Each channel delivers two codes per half-rate clock: one on a delayed lane and one on a direct lane. The block puts the two codes back into time order. It takes the absolute difference between each code and the one before it. A run of back-to-back failing samples is merged into a single event. Results are kept as whole-code event counts and failing-sample counts, never as per-bit tallies. The most recent event is held for reading: its starting sample index, its length, and the codes on either side of the first jump. From these, outage time can be derived. Every channel is handled independently, and all channels share one margin input.

Top module: `code_jump_monitor`

## Requirements
- R1: After reset, both counters of every channel read 0 and the report valid flag is 0.
- R2: Within one enabled cycle the delayed-lane code is the earlier sample. It is compared with the direct-lane code of the previous enabled cycle, and the direct-lane code is then compared with the delayed-lane code of the same cycle.
- R3: A sample is in error only when the unsigned absolute difference from its predecessor is strictly greater than `jump_limit`. A difference equal to the limit is not an error, and jumps in either direction count, including the full range 0 to 255.
- R4: While `enable` is 0 the lane inputs are ignored. The first delayed-lane sample after reset, or after `enable` returns to 1, is never flagged.
- R5: A run of consecutive error samples, even one that spans cycles, adds exactly 1 to the event counter when it begins. Every error sample adds 1 to the error-sample counter.
- R6: Sample indices count from 0 after reset, advance by 2 per enabled cycle, and give the delayed lane index 2k and the direct lane 2k+1. An event closes at the first clean sample or when `enable` drops. In the following cycle the report shows the start index, the length in samples, the code before the first error sample, and that error sample's code.
- R7: `rpt_valid` stays 1 until `rpt_ack` is pulsed. A newly closed event overwrites the report even while valid is set. If an event closes in the same cycle as an ack, the report stays valid and shows the new event.
- R8: Both counters and the event length saturate at their all-ones value.
- R9: `clear` zeroes both counters of every channel in the next cycle. It does not reset the sample index or the report.
- R10: Errors on one channel never change another channel's counters or report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Monitoring active; lanes are ignored while low |
| clear | input | 1 | Synchronous clear of all counters |
| jump_limit | input | W | Largest permitted code change between neighbouring samples |
| early_code | input | NCH x W | Delayed-lane code per channel (earlier sample) |
| late_code | input | NCH x W | Direct-lane code per channel (later sample) |
| rpt_ack | input | NCH | Acknowledge and drop the held report |
| event_count | output | NCH x CNT_W | Saturating count of merged events |
| error_count | output | NCH x CNT_W | Saturating count of error samples |
| rpt_valid | output | NCH | Held report present |
| rpt_start | output | NCH x IDX_W | Sample index of the first error sample |
| rpt_length | output | NCH x LEN_W | Event length in samples |
| rpt_before | output | NCH x W | Code just before the first jump |
| rpt_after | output | NCH x W | Code of the first error sample |

## Verification
The hardest situations to reach are the ones where an event boundary falls between the two lanes of one cycle. In one case a run ends on the delayed lane and a new run starts on the direct lane, so one cycle must both close a report and open an event. In another case a run is cut short by `enable` dropping. The stimulus table walks hand-picked code pairs through both lane orders, exact-threshold differences and full-scale swings. Directed sequences then hold alternating codes for many cycles to drive the length and both counters into saturation. They also pulse acknowledge in the same cycle that an event closes.

// File: rtl/cjm_pkg.sv
`timescale 1ns/1ps
package cjm_pkg;
   // error pattern of one half-rate cycle: {earlier sample, later sample}
   typedef enum logic [1:0] {
      PAIR_CLEAN = 2'b00,
      PAIR_LATE  = 2'b01,
      PAIR_EARLY = 2'b10,
      PAIR_BOTH  = 2'b11
   } pair_err_e;
endpackage

// File: rtl/cjm_jump_cmp.sv
`timescale 1ns/1ps
module cjm_jump_cmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] code_prev,
   input  logic [W-1:0] code_cur,
   input  logic [W-1:0] limit,
   output logic         over
);
   localparam int DW = W + 1;
   logic [DW-1:0] diff;
   logic [DW-1:0] mag;

   always_comb begin
      diff = {1'b0, code_cur} - {1'b0, code_prev};
      mag  = diff[DW-1] ? (~diff + DW'(1)) : diff;
      over = mag > {1'b0, limit};
   end
endmodule

// File: rtl/cjm_sat_counter.sv
`timescale 1ns/1ps
module cjm_sat_counter #(
   parameter int WIDTH  = 16,
   parameter int STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [STEP_W-1:0] inc,
   output logic [WIDTH-1:0]  count
);
   if (STEP_W > WIDTH) begin : g_bad_step
      $error("cjm_sat_counter: STEP_W must not exceed WIDTH");
   end

   logic [WIDTH:0]   sum;
   logic [WIDTH-1:0] cnt_q;

   always_comb sum = {1'b0, cnt_q} + {{(WIDTH + 1 - STEP_W){1'b0}}, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (sum[WIDTH]) cnt_q <= '1;
      else              cnt_q <= sum[WIDTH-1:0];
   end

   assign count = cnt_q;

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q >= $past(cnt_q)));                         // R8
   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));                                    // R9
endmodule

// File: rtl/cjm_run_tracker.sv
`timescale 1ns/1ps
module cjm_run_tracker
   import cjm_pkg::*;
#(
   parameter int W     = 8,
   parameter int IDX_W = 16,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             err_early,
   input  logic             err_late,
   input  logic [IDX_W-1:0] idx_early,
   input  logic [W-1:0]     code_prev,
   input  logic [W-1:0]     code_early,
   input  logic [W-1:0]     code_late,
   input  logic             ack,
   output logic             evt_start,
   output logic             rpt_valid,
   output logic [IDX_W-1:0] rpt_start,
   output logic [LEN_W-1:0] rpt_length,
   output logic [W-1:0]     rpt_before,
   output logic [W-1:0]     rpt_after
);
   if (LEN_W < 2) begin : g_bad_len
      $error("cjm_run_tracker: LEN_W must be at least 2");
   end

   function automatic logic [LEN_W-1:0] len_plus(input logic [LEN_W-1:0] a,
                                                  input logic [1:0] b);
      logic [LEN_W:0] s;
      s = {1'b0, a} + {{(LEN_W - 1){1'b0}}, b};
      return s[LEN_W] ? '1 : s[LEN_W-1:0];
   endfunction

   // open run
   logic             run_q,   run_d;
   logic [IDX_W-1:0] start_q, start_d;
   logic [LEN_W-1:0] len_q,   len_d;
   logic [W-1:0]     bef_q,   bef_d;
   logic [W-1:0]     aft_q,   aft_d;
   // closing run to publish
   logic             pub;
   logic [IDX_W-1:0] pub_start;
   logic [LEN_W-1:0] pub_len;
   logic [W-1:0]     pub_bef, pub_aft;
   // held report
   logic             rv_q;
   logic [IDX_W-1:0] rs_q;
   logic [LEN_W-1:0] rl_q;
   logic [W-1:0]     rb_q, ra_q;

   pair_err_e pat;

   always_comb begin
      pat       = pair_err_e'({err_early, err_late});
      run_d     = run_q;
      start_d   = start_q;
      len_d     = len_q;
      bef_d     = bef_q;
      aft_d     = aft_q;
      pub       = 1'b0;
      pub_start = start_q;
      pub_len   = len_q;
      pub_bef   = bef_q;
      pub_aft   = aft_q;
      evt_start = 1'b0;
      if (!en) begin
         pub   = run_q;
         run_d = 1'b0;
      end else begin
         unique case (pat)
            PAIR_CLEAN: begin
               pub   = run_q;
               run_d = 1'b0;
            end
            PAIR_EARLY: begin
               pub   = 1'b1;
               run_d = 1'b0;
               if (run_q) begin
                  pub_len = len_plus(len_q, 2'd1);
               end else begin
                  evt_start = 1'b1;
                  pub_start = idx_early;
                  pub_len   = LEN_W'(1);
                  pub_bef   = code_prev;
                  pub_aft   = code_early;
               end
            end
            PAIR_LATE: begin
               pub       = run_q;
               evt_start = 1'b1;
               run_d     = 1'b1;
               start_d   = idx_early + IDX_W'(1);
               len_d     = LEN_W'(1);
               bef_d     = code_early;
               aft_d     = code_late;
            end
            PAIR_BOTH: begin
               run_d = 1'b1;
               if (run_q) begin
                  len_d = len_plus(len_q, 2'd2);
               end else begin
                  evt_start = 1'b1;
                  start_d   = idx_early;
                  len_d     = LEN_W'(2);
                  bef_d     = code_prev;
                  aft_d     = code_early;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         start_q <= '0;
         len_q   <= '0;
         bef_q   <= '0;
         aft_q   <= '0;
         rv_q    <= 1'b0;
         rs_q    <= '0;
         rl_q    <= '0;
         rb_q    <= '0;
         ra_q    <= '0;
      end else begin
         run_q   <= run_d;
         start_q <= start_d;
         len_q   <= len_d;
         bef_q   <= bef_d;
         aft_q   <= aft_d;
         if (pub) begin
            rv_q <= 1'b1;
            rs_q <= pub_start;
            rl_q <= pub_len;
            rb_q <= pub_bef;
            ra_q <= pub_aft;
         end else if (ack) begin
            rv_q <= 1'b0;
         end
      end
   end

   assign rpt_valid  = rv_q;
   assign rpt_start  = rs_q;
   assign rpt_length = rl_q;
   assign rpt_before = rb_q;
   assign rpt_after  = ra_q;

   AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rv_q && !ack) |=> rv_q);                                  // R7
   AST_RPT_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rv_q |-> (rl_q != '0));                                    // R6
   AST_RUN_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (len_q != '0));                                  // R5
endmodule

// File: rtl/cjm_channel.sv
`timescale 1ns/1ps
module cjm_channel #(
   parameter int W     = 8,
   parameter int IDX_W = 16,
   parameter int LEN_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [W-1:0]     limit,
   input  logic [W-1:0]     code_early,
   input  logic [W-1:0]     code_late,
   input  logic             ack,
   output logic [CNT_W-1:0] evt_count,
   output logic [CNT_W-1:0] err_count,
   output logic             rpt_valid,
   output logic [IDX_W-1:0] rpt_start,
   output logic [LEN_W-1:0] rpt_length,
   output logic [W-1:0]     rpt_before,
   output logic [W-1:0]     rpt_after
);
   logic [W-1:0]     prev_q;
   logic             prev_ok_q;
   logic [IDX_W-1:0] idx_q;
   logic             over_early, over_late;
   logic             err_early, err_late;
   logic             evt_start;
   logic [1:0]       err_inc;

   cjm_jump_cmp #(.W(W)) u_cmp_early (
      .code_prev(prev_q), .code_cur(code_early), .limit(limit), .over(over_early));
   cjm_jump_cmp #(.W(W)) u_cmp_late (
      .code_prev(code_early), .code_cur(code_late), .limit(limit), .over(over_late));

   always_comb begin
      err_early = en && prev_ok_q && over_early;
      err_late  = en && over_late;
      err_inc   = {1'b0, err_early} + {1'b0, err_late};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
         idx_q     <= '0;
      end else if (en) begin
         prev_q    <= code_late;
         prev_ok_q <= 1'b1;
         idx_q     <= idx_q + IDX_W'(2);
      end else begin
         prev_ok_q <= 1'b0;
      end
   end

   cjm_run_tracker #(.W(W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .en(en),
      .err_early(err_early), .err_late(err_late), .idx_early(idx_q),
      .code_prev(prev_q), .code_early(code_early), .code_late(code_late),
      .ack(ack), .evt_start(evt_start),
      .rpt_valid(rpt_valid), .rpt_start(rpt_start), .rpt_length(rpt_length),
      .rpt_before(rpt_before), .rpt_after(rpt_after));

   cjm_sat_counter #(.WIDTH(CNT_W), .STEP_W(1)) u_evt_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(evt_start), .count(evt_count));
   cjm_sat_counter #(.WIDTH(CNT_W), .STEP_W(2)) u_err_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(err_inc), .count(err_count));

   AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !evt_start);                                       // R4
   AST_START_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      evt_start |-> (err_inc != 2'd0));                          // R5
endmodule

// File: rtl/code_jump_monitor.sv
`timescale 1ns/1ps
module code_jump_monitor #(
   parameter int NCH   = 2,
   parameter int W     = 8,
   parameter int IDX_W = 16,
   parameter int LEN_W = 8,
   parameter int CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable,
   input  logic                       clear,
   input  logic [W-1:0]               jump_limit,
   input  logic [NCH-1:0][W-1:0]      early_code,
   input  logic [NCH-1:0][W-1:0]      late_code,
   input  logic [NCH-1:0]             rpt_ack,
   output logic [NCH-1:0][CNT_W-1:0]  event_count,
   output logic [NCH-1:0][CNT_W-1:0]  error_count,
   output logic [NCH-1:0]             rpt_valid,
   output logic [NCH-1:0][IDX_W-1:0]  rpt_start,
   output logic [NCH-1:0][LEN_W-1:0]  rpt_length,
   output logic [NCH-1:0][W-1:0]      rpt_before,
   output logic [NCH-1:0][W-1:0]      rpt_after
);
   if (NCH < 1) begin : g_bad_nch
      $error("code_jump_monitor: NCH must be at least 1");
   end
   if (W < 2 || W > 16) begin : g_bad_w
      $error("code_jump_monitor: W must lie in 2..16");
   end
   if (IDX_W < 2 || CNT_W < 2) begin : g_bad_cnt
      $error("code_jump_monitor: IDX_W and CNT_W must be at least 2");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cjm_channel #(.W(W), .IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .en(enable), .clr(clear),
         .limit(jump_limit),
         .code_early(early_code[c]), .code_late(late_code[c]),
         .ack(rpt_ack[c]),
         .evt_count(event_count[c]), .err_count(error_count[c]),
         .rpt_valid(rpt_valid[c]), .rpt_start(rpt_start[c]),
         .rpt_length(rpt_length[c]), .rpt_before(rpt_before[c]),
         .rpt_after(rpt_after[c]));
   end
endmodule

// File: tb/tb_code_jump_monitor.sv
`timescale 1ns/1ps
module tb_code_jump_monitor;
   localparam int NCH = 2, W = 8, IDX_W = 16, LEN_W = 4, CNT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic clear = 1'b0;
   logic [W-1:0] jump_limit = 8'd6;
   logic [NCH-1:0][W-1:0] early_code = '0;
   logic [NCH-1:0][W-1:0] late_code = '0;
   logic [NCH-1:0] rpt_ack = '0;
   logic [NCH-1:0][CNT_W-1:0] event_count, error_count;
   logic [NCH-1:0] rpt_valid;
   logic [NCH-1:0][IDX_W-1:0] rpt_start;
   logic [NCH-1:0][LEN_W-1:0] rpt_length;
   logic [NCH-1:0][W-1:0] rpt_before, rpt_after;

   int ntests = 0, nfail = 0, k = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   code_jump_monitor #(.NCH(NCH), .W(W), .IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .jump_limit(jump_limit),
      .early_code(early_code), .late_code(late_code), .rpt_ack(rpt_ack),
      .event_count(event_count), .error_count(error_count), .rpt_valid(rpt_valid),
      .rpt_start(rpt_start), .rpt_length(rpt_length), .rpt_before(rpt_before),
      .rpt_after(rpt_after));

   // early, late, err, evt, valid, start, len, before, after
   localparam int VN = 13;
   localparam logic [60:0] VEC [VN] = '{
      {8'd100, 8'd101, 4'd0,  4'd0, 1'b0, 16'd0,  4'd0, 8'd0,   8'd0},
      {8'd103, 8'd109, 4'd0,  4'd0, 1'b0, 16'd0,  4'd0, 8'd0,   8'd0},
      {8'd109, 8'd116, 4'd1,  4'd1, 1'b0, 16'd0,  4'd0, 8'd0,   8'd0},
      {8'd117, 8'd118, 4'd1,  4'd1, 1'b1, 16'd5,  4'd1, 8'd109, 8'd116},
      {8'd60,  8'd62,  4'd2,  4'd2, 1'b1, 16'd8,  4'd1, 8'd118, 8'd60},
      {8'd200, 8'd10,  4'd4,  4'd3, 1'b1, 16'd8,  4'd1, 8'd118, 8'd60},
      {8'd0,   8'd255, 4'd6,  4'd3, 1'b1, 16'd8,  4'd1, 8'd118, 8'd60},
      {8'd250, 8'd249, 4'd6,  4'd3, 1'b1, 16'd10, 4'd4, 8'd62,  8'd200},
      {8'd249, 8'd240, 4'd7,  4'd4, 1'b1, 16'd10, 4'd4, 8'd62,  8'd200},
      {8'd230, 8'd235, 4'd8,  4'd4, 1'b1, 16'd17, 4'd2, 8'd249, 8'd240},
      {8'd240, 8'd250, 4'd9,  4'd5, 1'b1, 16'd17, 4'd2, 8'd249, 8'd240},
      {8'd251, 8'd1,   4'd10, 4'd6, 1'b1, 16'd21, 4'd1, 8'd240, 8'd250},
      {8'd1,   8'd1,   4'd10, 4'd6, 1'b1, 16'd23, 4'd1, 8'd251, 8'd1}
   };

   task automatic chk(input string req, input int act, input int exp);
      ntests++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_rpt(input string req, input int c, input int st, input int ln,
                          input int bf, input int af);
      chk({req, " valid"},  int'(rpt_valid[c]), 1);
      chk({req, " start"},  int'(rpt_start[c]), st);
      chk({req, " length"}, int'(rpt_length[c]), ln);
      chk({req, " before"}, int'(rpt_before[c]), bf);
      chk({req, " after"},  int'(rpt_after[c]), af);
   endtask

   // drive at posedge+1, advance one clock, return at posedge+1
   task automatic cyc(input logic en, input int e0, input int l0, input logic ack0 = 1'b0,
                      input int e1 = 50, input int l1 = 50);
      enable        = en;
      early_code[0] = W'(e0);
      late_code[0]  = W'(l0);
      early_code[1] = W'(e1);
      late_code[1]  = W'(l1);
      rpt_ack[0]    = ack0;
      @(posedge clk);
      #1;
      if (en) k++;
      rpt_ack = '0;
   endtask

   initial begin
      #(5 * 100000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      int first_idx;
      early_code[1] = 8'd50;
      late_code[1]  = 8'd50;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      for (int c = 0; c < NCH; c++) begin   // R1
         chk("R1 event count", int'(event_count[c]), 0);
         chk("R1 error count", int'(error_count[c]), 0);
         chk("R1 report valid", int'(rpt_valid[c]), 0);
      end

      // R2 R3 R5 R6 R7: lane ordering, thresholds, merging, overwrite
      for (int i = 0; i < VN; i++) begin
         cyc(1'b1, int'(VEC[i][60:53]), int'(VEC[i][52:45]));
         chk("R3/R5 error count", int'(error_count[0]), int'(VEC[i][44:41]));
         chk("R2/R5 event count", int'(event_count[0]), int'(VEC[i][40:37]));
         chk("R6 valid", int'(rpt_valid[0]), int'(VEC[i][36]));
         if (VEC[i][36])
            chk_rpt("R6/R7 table", 0, int'(VEC[i][35:20]), int'(VEC[i][19:16]),
                    int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      end
      chk("R10 other channel errors", int'(error_count[1]), 0);
      chk("R10 other channel valid", int'(rpt_valid[1]), 0);

      cyc(1'b1, 1, 1, 1'b1);                       // R7 ack drops report
      chk("R7 ack clears valid", int'(rpt_valid[0]), 0);

      cyc(1'b0, 200, 3);                           // R4 disabled lanes ignored
      chk("R4 idle errors", int'(error_count[0]), 10);
      chk("R4 idle valid", int'(rpt_valid[0]), 0);
      cyc(1'b1, 200, 200);                         // R4 first sample suppressed
      chk("R4 first sample", int'(error_count[0]), 10);
      cyc(1'b1, 200, 220);
      chk("R5 late error", int'(error_count[0]), 11);
      cyc(1'b1, 220, 220);
      chk_rpt("R6 index across idle gap", 0, 31, 1, 200, 220);
      cyc(1'b1, 240, 240, 1'b1);                   // R7 ack with new report
      chk_rpt("R7 ack and new event", 0, 34, 1, 220, 240);
      chk("R5 event count", int'(event_count[0]), 8);
      cyc(1'b1, 100, 0);
      chk("R5 run errors", int'(error_count[0]), 14);
      cyc(1'b0, 7, 7);                             // R6 enable drop closes run
      chk_rpt("R6 close on disable", 0, 36, 2, 240, 100);
      chk("R5 event count after close", int'(event_count[0]), 9);

      cyc(1'b1, 0, 0);
      cyc(1'b1, 100, 200);
      chk("R8 error counter saturates", int'(error_count[0]), 15);
      cyc(1'b1, 0, 100);
      chk("R8 error counter holds", int'(error_count[0]), 15);
      cyc(1'b1, 100, 100);
      chk_rpt("R6 four sample run", 0, 40, 4, 0, 100);
      for (int i = 0; i < 6; i++)
         cyc(1'b1, (i % 2 == 0) ? 0 : 100, (i % 2 == 0) ? 0 : 100);
      chk("R8 event counter saturates", int'(event_count[0]), 15);

      first_idx = 2 * k;
      for (int i = 0; i < 10; i++) cyc(1'b1, 0, 100);
      cyc(1'b1, 100, 100);
      chk_rpt("R8 length saturates", 0, first_idx, 15, 100, 0);

      clear = 1'b1;                                // R9
      cyc(1'b1, 100, 100);
      clear = 1'b0;
      chk("R9 clear events", int'(event_count[0]), 0);
      chk("R9 clear errors", int'(error_count[0]), 0);
      chk("R9 report kept", int'(rpt_valid[0]), 1);
      first_idx = 2 * k + 1;
      cyc(1'b1, 100, 0);
      cyc(1'b1, 0, 0);
      chk_rpt("R9 index not reset", 0, first_idx, 1, 100, 0);
      chk("R9 counting resumes", int'(event_count[0]), 1);

      cyc(1'b1, 0, 0, 1'b0, 50, 90);               // R10
      chk("R10 channel 1 errors", int'(error_count[1]), 1);
      chk("R10 channel 1 events", int'(event_count[1]), 1);
      chk("R10 channel 0 untouched", int'(error_count[0]), 1);
      cyc(1'b1, 0, 0, 1'b0, 90, 90);
      chk_rpt("R10 channel 1 report", 1, 2 * k - 3, 1, 50, 90);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule